// File: doc/BRIEF.md
# Processing-Element Activity Mask and Global-Active Reduction

This block sits beside the array controller of a SIMD array. It holds one activity flag per processing element, gives each element a fixed identity number, and turns the single broadcast execute strobe into one enable per element. Only elements whose flag is set run a broadcast parallel instruction. Elements whose flag is clear see no enable, so their state does not change.

The controller reaches the flags through a load/store port. A store to the mask window (base address plus element identity) sets or clears that element's flag. A load from the same address returns the flag. A load from a separate fixed address returns the OR of all flags, which the controller uses to leave a conditional loop once no element is still active.

The OR is computed by a registered binary tree, so its result lags flag stores by log2 of the element count in cycles. A busy output covers that window. Loads answer one cycle after the request.

Top module: `pe_activity_ctrl`

## Requirements
- R1: After reset every activity flag is 1, `or_busy` is 0, and a load of the global-active address (default 0x9005) returns 1.
- R2: A store with `req_addr` = MASK_BASE (default 0x90000) + i, for i < N, writes only bit 0 of `req_wdata` into flag i and leaves every other flag unchanged.
- R3: Every load gets `rsp_valid` high on the cycle after the request. A load from MASK_BASE + i, for i < N, returns flag i in bit 0 and zeros in all higher bits. A store produces no response.
- R4: A store to MASK_BASE + i with N <= i < WIN_SIZE (default 256) changes no flag, and a load from such an address returns 0.
- R5: `pe_exec_en[i]` equals `exec_strobe` AND flag i in the same cycle, with no register in the path.
- R6: When `or_busy` is 0, a load of the global-active address returns the OR of all flags in bit 0, with zeros above it.
- R7: Each flag store raises `or_busy` for exactly ceil(log2 N) cycles, counted from the clock edge that takes the store. This is 3 cycles for N = 8. A new flag store restarts the count.
- R8: `pe_ident` slice i (bits i*ID_W to i*ID_W+ID_W-1) carries the constant value i.
- R9: A store to any address outside the mask window changes no flag, including the global-active address. A load from an address that is neither in the mask window nor the global-active address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Bus address |
| req_wdata | input | DATA_W | Store data; only bit 0 is used |
| rsp_valid | output | 1 | Load data valid (one cycle after the load) |
| rsp_rdata | output | DATA_W | Load data |
| exec_strobe | input | 1 | Broadcast execute strobe for a parallel instruction |
| pe_exec_en | output | N | Per-element execute enable |
| pe_ident | output | N*ID_W | Packed identity of each element |
| or_busy | output | 1 | Global-active result not yet settled after a flag store |

## Verification
The assertions assume at most one bus request per cycle and fully defined request fields whenever `req_valid` is high. They also assume the controller waits for `or_busy` to fall before it trusts a global-active load. The settled-OR property holds only outside the busy window. The stimulus drives all request fields to known values on every request and idles with `req_valid` low between requests. Every global-active load that checks a value is issued only after `or_busy` has been seen low.

// File: rtl/pe_act_pkg.sv
package pe_act_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_MASK  = 2'd1,
        ACC_ORSUM = 2'd2
    } acc_kind_e;

    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pe_act_decode.sv
module pe_act_decode
    import pe_act_pkg::*;
#(
    parameter int                N          = 8,
    parameter int                ADDR_W     = 20,
    parameter logic [ADDR_W-1:0] MASK_BASE  = 20'h90000,
    parameter int                WIN_SIZE   = 256,
    parameter logic [ADDR_W-1:0] ORSUM_ADDR = 20'h09005,
    localparam int               ID_W       = idx_width(N)
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [ID_W-1:0]   idx
);
    logic [ADDR_W-1:0] off;
    logic              in_win;

    always_comb begin
        off    = addr - MASK_BASE;
        in_win = (addr >= MASK_BASE) && (off < ADDR_W'(WIN_SIZE));
        idx    = off[ID_W-1:0];
        kind   = ACC_NONE;
        if (in_win) begin
            if (off < ADDR_W'(N)) begin
                kind = ACC_MASK;
            end
        end else if (addr == ORSUM_ADDR) begin
            kind = ACC_ORSUM;
        end
    end
endmodule

// File: rtl/pe_act_mask_bank.sv
module pe_act_mask_bank
    import pe_act_pkg::*;
#(
    parameter int  N    = 8,
    localparam int ID_W = idx_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ID_W-1:0] wr_idx,
    input  logic            wr_bit,
    input  logic            exec_strobe,
    output logic [N-1:0]    mask_q,
    output logic [N-1:0]    exec_en
);
    logic [N-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (wr_en) begin
            mask_d[wr_idx] = wr_bit;
        end
        exec_en = {N{exec_strobe}} & mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/pe_act_or_tree.sv
module pe_act_or_tree #(
    parameter int  N      = 8,
    localparam int LEVELS = (N < 2) ? 0 : $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] leaves,
    output logic         any_q
);
    generate
        if (LEVELS == 0) begin : g_flat
            assign any_q = leaves[0];
        end else begin : g_tree
            localparam int P = 1 << LEVELS;

            logic [P-1:0]   lf;
            logic [P-1:1]   node_d;
            logic [P-1:1]   node_q;
            logic [2*P-1:1] all_n;

            always_comb begin
                lf        = '0;
                lf[N-1:0] = leaves;
                all_n     = {lf, node_q};
                node_d    = node_q;
                for (int i = 1; i < P; i++) begin
                    node_d[i] = all_n[2*i] | all_n[2*i+1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    node_q <= '1;
                end else begin
                    node_q <= node_d;
                end
            end

            assign any_q = all_n[1];
        end
    endgenerate
endmodule

// File: rtl/pe_activity_ctrl.sv
module pe_activity_ctrl
    import pe_act_pkg::*;
#(
    parameter int                N          = 8,
    parameter int                ADDR_W     = 20,
    parameter int                DATA_W     = 32,
    parameter logic [ADDR_W-1:0] MASK_BASE  = 20'h90000,
    parameter int                WIN_SIZE   = 256,
    parameter logic [ADDR_W-1:0] ORSUM_ADDR = 20'h09005,
    localparam int               ID_W       = idx_width(N),
    localparam int               LEVELS     = (N < 2) ? 0 : $clog2(N),
    localparam int               CNT_W      = (LEVELS < 1) ? 1 : $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              exec_strobe,
    output logic [N-1:0]      pe_exec_en,
    output logic [N*ID_W-1:0] pe_ident,
    output logic              or_busy
);
    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic [CNT_W-1:0]  busy_cnt;
    } ctl_t;

    ctl_t            ctl_d, ctl_q;
    acc_kind_e       kind;
    logic [ID_W-1:0] idx;
    logic [N-1:0]    mask_q;
    logic            or_any;
    logic            mask_wr;
    logic            wdata_hi_unused;

    assign wdata_hi_unused = |req_wdata[DATA_W-1:1];

    pe_act_decode #(
        .N(N), .ADDR_W(ADDR_W), .MASK_BASE(MASK_BASE),
        .WIN_SIZE(WIN_SIZE), .ORSUM_ADDR(ORSUM_ADDR)
    ) u_decode (
        .addr(req_addr),
        .kind(kind),
        .idx (idx)
    );

    assign mask_wr = req_valid && req_write && (kind == ACC_MASK);

    pe_act_mask_bank #(.N(N)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mask_wr),
        .wr_idx     (idx),
        .wr_bit     (req_wdata[0]),
        .exec_strobe(exec_strobe),
        .mask_q     (mask_q),
        .exec_en    (pe_exec_en)
    );

    pe_act_or_tree #(.N(N)) u_tree (
        .clk   (clk),
        .rst_n (rst_n),
        .leaves(mask_q),
        .any_q (or_any)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_ident
            assign pe_ident[g*ID_W +: ID_W] = ID_W'(g);
        end
    endgenerate

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = req_valid && !req_write;
        ctl_d.rsp_data  = '0;
        if (req_valid && !req_write) begin
            case (kind)
                ACC_MASK:  ctl_d.rsp_data[0] = mask_q[idx];
                ACC_ORSUM: ctl_d.rsp_data[0] = or_any;
                default:   ctl_d.rsp_data    = '0;
            endcase
        end
        if (mask_wr) begin
            ctl_d.busy_cnt = CNT_W'(LEVELS);
        end else if (ctl_q.busy_cnt != '0) begin
            ctl_d.busy_cnt = ctl_q.busy_cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_rdata = ctl_q.rsp_data;
    assign or_busy   = (ctl_q.busy_cnt != '0);
endmodule

// File: rtl/pe_act_checker.sv
module pe_act_checker #(
    parameter int                N         = 8,
    parameter int                ADDR_W    = 20,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] MASK_BASE = 20'h90000,
    localparam int               LEVELS    = (N < 2) ? 0 : $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic              exec_strobe,
    input logic [N-1:0]      pe_exec_en,
    input logic              or_busy,
    input logic [N-1:0]      mask_q,
    input logic              or_any
);
    logic [ADDR_W-1:0] c_off;
    logic              c_hit;
    logic              c_store_hit;
    logic              c_load;

    assign c_off       = req_addr - MASK_BASE;
    assign c_hit       = (req_addr >= MASK_BASE) && (c_off < ADDR_W'(N));
    assign c_store_hit = req_valid && req_write && c_hit;
    assign c_load      = req_valid && !req_write;

    // R1
    a_r1_reset_all_active: assert property (@(posedge clk)
        !rst_n |=> (&mask_q));

    // R2
    a_r2_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        c_store_hit |=> mask_q[$past(c_off)] == $past(req_wdata[0]));

    // R3
    a_r3_rsp_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        c_load |=> rsp_valid);

    // R3
    a_r3_no_rsp_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !c_load |=> !rsp_valid);

    // R4 and R9
    a_r4_stray_store_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        !c_store_hit |=> mask_q == $past(mask_q));

    // R5
    a_r5_no_strobe_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_strobe |-> pe_exec_en == '0);

    // R5
    a_r5_idle_pe_never_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_exec_en & ~mask_q) == '0);

    // R6
    a_r6_settled_or: assert property (@(posedge clk) disable iff (!rst_n)
        !or_busy |-> or_any == (|mask_q));

    // R7
    a_r7_busy_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        (LEVELS > 0) && c_store_hit |=> or_busy);
endmodule

bind pe_activity_ctrl pe_act_checker #(
    .N(N), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MASK_BASE(MASK_BASE)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .exec_strobe(exec_strobe),
    .pe_exec_en (pe_exec_en),
    .or_busy    (or_busy),
    .mask_q     (mask_q),
    .or_any     (or_any)
);

// File: tb/pe_activity_ctrl_tb.sv
module pe_activity_ctrl_tb;
    localparam int          N      = 8;
    localparam int          ID_W   = 3;
    localparam int          ADDR_W = 20;
    localparam int          DATA_W = 32;
    localparam logic [19:0] BASE   = 20'h90000;
    localparam logic [19:0] ORA    = 20'h09005;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic              exec_strobe = 1'b0;
    logic [N-1:0]      pe_exec_en;
    logic [N*ID_W-1:0] pe_ident;
    logic              or_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [N-1:0] exp_mask = '1;
    logic [DATA_W-1:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    pe_activity_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .exec_strobe(exec_strobe), .pe_exec_en(pe_exec_en),
        .pe_ident(pe_ident), .or_busy(or_busy)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic store(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        if (a >= BASE && (a - BASE) < N) exp_mask[a - BASE] = d[0];
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic load(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                        input string req);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_settle();
        while (or_busy) @(negedge clk);
    endtask

    task automatic exec_check(input string req);
        exec_strobe = 1'b1;
        #1;
        chk(req, DATA_W'(pe_exec_en), DATA_W'(exp_mask));
        exec_strobe = 1'b0;
        #1;
        chk(req, DATA_W'(pe_exec_en), '0);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R3 unexpected response actual=%0h expected=none", rsp_rdata);
            end else begin
                chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        int busy_cycles;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy after reset", DATA_W'(or_busy), '0);
        exec_check("R1 R5 all enabled after reset");
        load(ORA, 32'd1, "R1 global-active after reset");
        // R8 identities
        for (int i = 0; i < N; i++)
            chk("R8 identity", DATA_W'(pe_ident[i*ID_W +: ID_W]), DATA_W'(i));

        // R2 / R3 single flag clear, upper data bits ignored
        store(BASE + 3, 32'hFFFF_FFFE);
        load(BASE + 3, 32'd0, "R2 R3 PE3 cleared");
        load(BASE + 2, 32'd1, "R2 PE2 untouched");
        store(BASE + 5, 32'h0000_0002);
        load(BASE + 5, 32'd0, "R2 only bit0 used for PE5");
        store(BASE + 7, 32'hFFFF_FFFF);
        load(BASE + 7, 32'd1, "R3 zeros above bit0");
        exec_check("R5 gated enables");

        // R7 busy window
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = BASE + 1; req_wdata = 32'd0;
        exp_mask[1] = 1'b0;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        busy_cycles = 0;
        while (or_busy && busy_cycles < 20) begin
            busy_cycles++;
            @(negedge clk);
        end
        chk("R7 busy cycles", DATA_W'(busy_cycles), 32'd3);

        // R4 out-of-range id
        store(BASE + 8, 32'd0);
        store(BASE + 200, 32'd0);
        exec_check("R4 out-of-range store ignored");
        load(BASE + 8, 32'd0, "R4 out-of-range load");
        load(BASE + 8'hC0, 32'd0, "R4 window tail load");

        // R9 other addresses
        store(ORA, 32'd0);
        store(20'h20000, 32'd0);
        store(20'h00000, 32'd0);
        exec_check("R9 foreign stores ignored");
        load(20'h12345, 32'd0, "R9 foreign load");
        load(BASE - 1, 32'd0, "R9 below window load");

        // R6 global-active after clearing all
        for (int i = 0; i < N; i++) store(BASE + i, 32'd0);
        wait_settle();
        load(ORA, 32'd0, "R6 none active");
        exec_check("R5 none active");
        store(BASE + 6, 32'd1);
        wait_settle();
        load(ORA, 32'd1, "R6 one active");
        load(BASE + 6, 32'd1, "R2 PE6 set");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R3 missing responses actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule